// File: doc/BRIEF.md
# Half-duplex serial exchange engine

This block moves a short burst of bytes between a local byte buffer and one of two peripherals. The peripherals share a single bidirectional data wire and a clock driven by the engine. The exchange is full-duplex in effect but split in time. In every bit period the engine first hands the wire to the peripheral and captures one incoming bit on a falling clock. It then takes the wire back and presents its own outgoing bit before it raises the clock.

A host fills the buffer through a write port, picks a target and a byte count, and pulses a start request. The engine first applies the select pattern of the target that is not addressed, then switches to the addressed one. It clocks out every byte least significant bit first and stores each byte that comes back in the slot of the byte it has just sent. After the last byte it disables transmit, leaves the data wire high and returns the selects to the pattern of the target that is not addressed. The host then reads the responses from the same buffer. The clock half period is a number of system cycles chosen per transfer.

Top module: `sw_xchg_top`

## Requirements
- R1: After reset: busy_o=0, done_o=0, sclk_o=1, tx_en_o=0, rx_en_o=0, data_oe_o=1, data_o=1, sel_o=2'b10.
- R2: A start request with byte_cnt_i equal to 0 or greater than DEPTH (8) is ignored: busy_o stays 0 and sel_o does not change.
- R3: sel_o is always one-hot, and the pattern for target t sets only bit t. On an accepted start, sel_o shows the pattern of the other target for the first busy cycle. It shows the pattern of target t from the second busy cycle until release, and the pattern of the other target after release.
- R4: In each bit the engine sets rx_en_o=1 and data_oe_o=0 while sclk_o is still high. sclk_o falls while rx_en_o=1 and data_oe_o=0. Before sclk_o rises, the engine sets rx_en_o=0 and data_oe_o=1 and puts the outgoing bit on data_o. tx_en_o is 1 at every rising edge of sclk_o.
- R5: The engine transmits buffer slots 0 to byte_cnt_i-1 in order, each least significant bit first, with one bit valid on data_o at each rising edge of sclk_o. There are exactly 8*byte_cnt_i rising edges per transfer.
- R6: The engine samples data_i while sclk_o is low. Each received bit enters the shift register at bit 7, so the first bit received in a byte ends up in bit 0. The completed byte overwrites the buffer slot that held the byte just sent.
- R7: Let H be half_i, or 1 when half_i is 0. In each bit, sclk_o stays low for H+1 system cycles: H cycles of clock-low phase and one cycle in which the outgoing bit is driven.
- R8: After the last bit, tx_en_o=0, data_oe_o=1 and data_o=1. busy_o stays high until the selects are released. done_o is high for exactly one cycle, the first cycle in which busy_o is low.
- R9: Host buffer writes made while busy_o=1 are ignored. rd_data_o returns the buffer slot at rd_addr_i.
- R10: A start request made while busy_o=1 is ignored: the running transfer keeps its target and byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, one cycle |
| byte_cnt_i | input | CW (4) | Number of bytes to exchange |
| target_i | input | 1 | Peripheral to address (0 or 1) |
| half_i | input | HALF_W (8) | Clock half period in system cycles (0 means 1) |
| wr_en_i | input | 1 | Host buffer write enable |
| wr_addr_i | input | AW (3) | Host buffer write slot |
| wr_data_i | input | DW (8) | Host buffer write byte |
| rd_addr_i | input | AW (3) | Host buffer read slot |
| rd_data_o | output | DW (8) | Buffer byte at rd_addr_i |
| sel_o | output | 2 | Complementary target selects, bit t addresses target t |
| rx_en_o | output | 1 | Receive path enable |
| tx_en_o | output | 1 | Transmit path enable |
| sclk_o | output | 1 | Serial clock, idles high |
| data_o | output | 1 | Outgoing data value |
| data_oe_o | output | 1 | Data wire drive enable (0 releases the wire) |
| data_i | input | 1 | Incoming data value from the wire |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong sequencer state shows up within one bit period as a clock edge that occurs while the wire is driven the wrong way. A lost or extra bit-counter step shows up at the end of the transfer as a wrong count of clock rises, and as bytes the peripheral model received skewed against those that were loaded. An error in the shift direction or in the write-back slot shows up only when the buffer is read after done_o, as bit-reversed or misplaced response bytes. A select or enable left in the wrong state is visible in the first idle cycle.

// File: rtl/sw_xchg_pkg.sv
package sw_xchg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL_PRE,
    ST_SEL_ON,
    ST_LOAD,
    ST_REL,
    ST_LOW,
    ST_DRV,
    ST_HIGH,
    ST_END,
    ST_FIN
  } xchg_state_e;

  // one-hot select pattern addressing target t
  function automatic logic [1:0] sel_pat(input logic t);
    return t ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/sw_xchg_timer.sv
module sw_xchg_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         last_o
);

  logic [W-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == limit_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (run_i && !last_o) begin
      cnt_q <= cnt_q + W'(1);
    end else begin
      cnt_q <= '0;
    end
  end

endmodule

// File: rtl/sw_xchg_buf.sv
module sw_xchg_buf #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];

endmodule

// File: rtl/sw_xchg_shift.sv
module sw_xchg_shift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          sample_i,
  input  logic          bit_i,
  output logic [DW-1:0] data_o,
  output logic          out_bit_o
);

  logic [DW-1:0] sh_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      out_q <= 1'b1;
    end else if (load_i) begin
      sh_q  <= load_data_i;
    end else if (sample_i) begin
      // send side leaves from bit 0, receive side enters at the top
      out_q <= sh_q[0];
      sh_q  <= {bit_i, sh_q[DW-1:1]};
    end
  end

  assign data_o    = sh_q;
  assign out_bit_o = out_q;

endmodule

// File: rtl/sw_xchg_top.sv
module sw_xchg_top
  import sw_xchg_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DW     = 8,
  parameter int HALF_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int BW    = $clog2(DW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CW-1:0]     byte_cnt_i,
  input  logic              target_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic [1:0]        sel_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              sclk_o,
  output logic              data_o,
  output logic              data_oe_o,
  input  logic              data_i,
  output logic              busy_o,
  output logic              done_o
);

  xchg_state_e       state_q;
  logic [1:0]        sel_q;
  logic              tgt_q;
  logic [CW-1:0]     cnt_q;
  logic [AW-1:0]     idx_q;
  logic [BW-1:0]     bit_q;
  logic [HALF_W-1:0] half_q;
  logic              done_q;

  logic              accept;
  logic              phase_run;
  logic              phase_last;
  logic              sample;
  logic              byte_end;
  logic              last_byte;
  logic              eng_we;
  logic [DW-1:0]     eng_rdata;
  logic [DW-1:0]     rx_byte;
  logic              out_bit;
  logic              buf_we;
  logic [AW-1:0]     buf_waddr;
  logic [DW-1:0]     buf_wdata;

  assign accept = start_i && (state_q == ST_IDLE) &&
                  (byte_cnt_i != '0) && (byte_cnt_i <= CW'(DEPTH));

  assign phase_run = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign sample    = (state_q == ST_LOW) && phase_last;
  assign byte_end  = (state_q == ST_HIGH) && phase_last && (bit_q == BW'(DW - 1));
  assign last_byte = (CW'(idx_q) + CW'(1)) == cnt_q;
  assign eng_we    = byte_end;

  // host port owns the buffer only while idle
  assign buf_we    = busy_o ? eng_we : wr_en_i;
  assign buf_waddr = busy_o ? idx_q : wr_addr_i;
  assign buf_wdata = busy_o ? rx_byte : wr_data_i;

  sw_xchg_timer #(.W(HALF_W)) timer_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (phase_run),
    .limit_i (half_q),
    .last_o  (phase_last)
  );

  sw_xchg_buf #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) buf_i (
    .clk_i     (clk_i),
    .we_i      (buf_we),
    .waddr_i   (buf_waddr),
    .wdata_i   (buf_wdata),
    .raddr_a_i (rd_addr_i),
    .rdata_a_o (rd_data_o),
    .raddr_b_i (idx_q),
    .rdata_b_o (eng_rdata)
  );

  sw_xchg_shift #(.DW(DW)) shift_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (state_q == ST_LOAD),
    .load_data_i (eng_rdata),
    .sample_i    (sample),
    .bit_i       (data_i),
    .data_o      (rx_byte),
    .out_bit_o   (out_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= sel_pat(1'b1);
      tgt_q   <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      bit_q   <= '0;
      half_q  <= HALF_W'(1);
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            tgt_q   <= target_i;
            cnt_q   <= byte_cnt_i;
            half_q  <= (half_i == '0) ? HALF_W'(1) : half_i;
            sel_q   <= sel_pat(!target_i);
            idx_q   <= '0;
            state_q <= ST_SEL_PRE;
          end
        end
        ST_SEL_PRE: begin
          sel_q   <= sel_pat(tgt_q);
          state_q <= ST_SEL_ON;
        end
        ST_SEL_ON: state_q <= ST_LOAD;
        ST_LOAD: begin
          bit_q   <= '0;
          state_q <= ST_REL;
        end
        ST_REL: state_q <= ST_LOW;
        ST_LOW: if (phase_last) state_q <= ST_DRV;
        ST_DRV: state_q <= ST_HIGH;
        ST_HIGH: begin
          if (phase_last) begin
            if (bit_q != BW'(DW - 1)) begin
              bit_q   <= bit_q + BW'(1);
              state_q <= ST_REL;
            end else if (last_byte) begin
              state_q <= ST_END;
            end else begin
              idx_q   <= idx_q + AW'(1);
              state_q <= ST_LOAD;
            end
          end
        end
        ST_END: state_q <= ST_FIN;
        ST_FIN: begin
          sel_q   <= sel_pat(!tgt_q);
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign sel_o     = sel_q;
  assign rx_en_o   = (state_q == ST_REL) || (state_q == ST_LOW);
  assign data_oe_o = !rx_en_o;
  assign sclk_o    = !((state_q == ST_LOW) || (state_q == ST_DRV));
  assign data_o    = ((state_q == ST_DRV) || (state_q == ST_HIGH)) ? out_bit : 1'b1;
  assign tx_en_o   = (state_q == ST_LOAD) || (state_q == ST_REL) || (state_q == ST_LOW) ||
                     (state_q == ST_DRV)  || (state_q == ST_HIGH);

endmodule

// File: rtl/sw_xchg_chk.sv
module sw_xchg_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [CW-1:0] byte_cnt_i,
  input logic [1:0]    sel_o,
  input logic          rx_en_o,
  input logic          tx_en_o,
  input logic          sclk_o,
  input logic          data_o,
  input logic          data_oe_o,
  input logic          busy_o,
  input logic          done_o
);

  // R3
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_o) == 1);

  // R3
  sel_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> (sel_o != $past(sel_o)));

  // R4
  fall_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> (rx_en_o && !data_oe_o));

  // R4
  rise_driven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> (data_oe_o && !rx_en_o && tx_en_o));

  // R8
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tx_en_o && data_oe_o && data_o && sclk_o));

  // R8
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));

  // R2
  zero_cnt_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && (byte_cnt_i == '0)) |=> !busy_o);

endmodule

bind sw_xchg_top sw_xchg_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .byte_cnt_i (byte_cnt_i),
  .sel_o      (sel_o),
  .rx_en_o    (rx_en_o),
  .tx_en_o    (tx_en_o),
  .sclk_o     (sclk_o),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/sw_xchg_top_tb_top.sv
`timescale 1ns/100ps
module sw_xchg_top_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] byte_cnt_i = '0;
  logic       target_i = 1'b0;
  logic [7:0] half_i = 8'd1;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic [1:0] sel_o;
  logic       rx_en_o, tx_en_o, sclk_o, data_o, data_oe_o;
  logic       data_i = 1'b0;
  logic       busy_o, done_o;

  int n_run = 0;
  int n_fail = 0;
  int bitpos = 0;
  int low_cnt = 0;
  int cur_h = 1;
  logic        cur_tgt = 1'b0;
  logic [63:0] rsp_bits = '0;
  logic [63:0] got_bits = '0;

  localparam int NV = 4;
  localparam logic [63:0] TX_V [NV] = '{
    64'h0000_0000_0000_00A5,
    64'h0012_3480_7E55_AAFF,
    64'hF0E1_D2C3_B4A5_9687,
    64'h0000_0000_00C3_0F01
  };
  localparam logic [63:0] RX_V [NV] = '{
    64'h0000_0000_0000_003C,
    64'h00FE_DC01_8899_0011,
    64'h0123_4567_89AB_CDEF,
    64'h0000_0000_0081_7E5A
  };
  localparam int CNT_V  [NV] = '{1, 7, 8, 3};
  localparam int TGT_V  [NV] = '{0, 1, 0, 1};
  localparam int HALF_V [NV] = '{1, 2, 0, 3};

  sw_xchg_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .byte_cnt_i(byte_cnt_i),
    .target_i(target_i), .half_i(half_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .sel_o(sel_o), .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .sclk_o(sclk_o),
    .data_o(data_o), .data_oe_o(data_oe_o), .data_i(data_i),
    .busy_o(busy_o), .done_o(done_o)
  );

  always #2.5 clk_i = ~clk_i;

  function automatic logic [1:0] pat(input logic t);
    return t ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // peripheral model: drives its bit after the clock falls
  always @(negedge sclk_o) begin
    if (busy_o === 1'b1) begin
      #1;
      chk(rx_en_o && !data_oe_o, "R4 fall with wire released",
          {rx_en_o, data_oe_o}, 2'b10);
      data_i = (bitpos < 64) ? rsp_bits[bitpos] : 1'b0;
    end
  end

  // peripheral model: takes the engine's bit on the rising clock
  always @(posedge sclk_o) begin
    if (busy_o === 1'b1) begin
      #1;
      chk(data_oe_o && !rx_en_o && tx_en_o, "R4 rise with wire driven",
          {data_oe_o, rx_en_o, tx_en_o}, 3'b101);
      chk(sel_o == pat(cur_tgt), "R3 target selected during bits", sel_o, pat(cur_tgt));
      if (bitpos < 64) got_bits[bitpos] = data_o;
      bitpos++;
    end
  end

  // clock-low width per bit
  always @(negedge clk_i) begin
    if (rst_ni && sclk_o === 1'b0) begin
      low_cnt++;
    end else if (low_cnt != 0) begin
      chk(low_cnt == cur_h + 1, "R7 clock low width", low_cnt, cur_h + 1);
      low_cnt = 0;
    end
  end

  task automatic host_write(input int a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 3'(a); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_start(input int cnt, input logic t, input int h);
    @(negedge clk_i);
    start_i = 1'b1; byte_cnt_i = 4'(cnt); target_i = t; half_i = 8'(h);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 8000; i++) begin
      if (done_o) begin ok = 1'b1; break; end
      @(negedge clk_i);
    end
  endtask

  task automatic check_end(input logic t, input int cnt);
    bit ok;
    wait_done(ok);
    chk(ok, "R8 done pulse seen", ok, 1);
    chk(!busy_o, "R8 busy low with done", busy_o, 0);
    chk(!tx_en_o && data_oe_o && data_o, "R8 line left high",
        {tx_en_o, data_oe_o, data_o}, 3'b011);
    chk(sel_o == pat(!t), "R3 selects released", sel_o, pat(!t));
    @(negedge clk_i);
    chk(!done_o, "R8 done one cycle", done_o, 0);
    chk(bitpos == 8 * cnt, "R5 clock rise count", bitpos, 8 * cnt);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [1:0] sel_before;
    repeat (3) @(negedge clk_i);
    chk({busy_o, done_o, sclk_o, tx_en_o, rx_en_o, data_oe_o, data_o} == 7'b0010011,
        "R1 reset outputs", {busy_o, done_o, sclk_o, tx_en_o, rx_en_o, data_oe_o, data_o},
        7'b0010011);
    chk(sel_o == 2'b10, "R1 reset selects", sel_o, 2'b10);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      for (int b = 0; b < CNT_V[v]; b++) host_write(b, TX_V[v][8*b +: 8]);
      rsp_bits = RX_V[v];
      got_bits = '0;
      bitpos = 0;
      cur_tgt = TGT_V[v][0];
      cur_h = (HALF_V[v] == 0) ? 1 : HALF_V[v];
      pulse_start(CNT_V[v], TGT_V[v][0], HALF_V[v]);
      chk(busy_o && sel_o == pat(!cur_tgt), "R3 other target first", sel_o, pat(!cur_tgt));
      @(negedge clk_i);
      chk(sel_o == pat(cur_tgt), "R3 addressed target second", sel_o, pat(cur_tgt));
      check_end(cur_tgt, CNT_V[v]);
      for (int b = 0; b < CNT_V[v]; b++) begin
        chk(got_bits[8*b +: 8] == TX_V[v][8*b +: 8], "R5 byte sent LSB first",
            got_bits[8*b +: 8], TX_V[v][8*b +: 8]);
        rd_addr_i = 3'(b);
        #1;
        chk(rd_data_o == RX_V[v][8*b +: 8], "R6 response in slot",
            rd_data_o, RX_V[v][8*b +: 8]);
      end
    end

    // zero and oversize counts
    sel_before = sel_o;
    pulse_start(0, 1'b0, 1);
    repeat (3) @(negedge clk_i);
    chk(!busy_o && sel_o == sel_before, "R2 zero count ignored", {busy_o, sel_o},
        {1'b0, sel_before});
    pulse_start(9, 1'b0, 1);
    repeat (3) @(negedge clk_i);
    chk(!busy_o && sel_o == sel_before, "R2 oversize count ignored", {busy_o, sel_o},
        {1'b0, sel_before});

    // write and start while busy
    host_write(0, 8'h11);
    host_write(1, 8'h22);
    rsp_bits = 64'h0000_0000_0000_C66B;
    got_bits = '0;
    bitpos = 0;
    cur_tgt = 1'b0;
    cur_h = 1;
    pulse_start(2, 1'b0, 1);
    repeat (20) @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 3'd0; wr_data_i = 8'hEE;
    start_i = 1'b1; byte_cnt_i = 4'd8; target_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; start_i = 1'b0;
    check_end(1'b0, 2);
    rd_addr_i = 3'd0;
    #1;
    chk(rd_data_o == 8'h6B, "R9 busy write ignored", rd_data_o, 8'h6B);
    chk(bitpos == 16, "R10 busy start ignored", bitpos, 16);
    rd_addr_i = 3'd1;
    #1;
    chk(rd_data_o == 8'hC6, "R9 read port", rd_data_o, 8'hC6);

    // idle host write then read
    host_write(5, 8'h5D);
    rd_addr_i = 3'd5;
    #1;
    chk(rd_data_o == 8'h5D, "R9 idle write", rd_data_o, 8'h5D);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule